// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block holds a small set of chip-level configuration words behind a simple register bus. Some of the words are guarded: they accept a write only after software has placed a 32-bit unlock key in the matching guard register. The bank offers two guarding schemes. In the first, a register has its own lock. The lock opens when its key is written and shuts itself after a short fixed window, so the guarded write has to follow the key almost at once. In the second, a pair of global enable registers must both hold their own keys before any guarded word accepts a write. Each configuration word drives a fixed group of output pins.

The scheme for each word is fixed at elaboration. A word assigned to a lock uses only that lock. Any other word uses the enable pair when the pair is present, and is freely writable when it is not. A write to a word that is still closed is dropped without effect and sets a sticky violation flag. Software can read that flag, and it is also driven on a pin.

The bus is single-cycle. A write is taken on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. The bus carries no stream traffic, so it has no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `keyreg_bank`

## Requirements
- R1: After reset every configuration word is 0, every lock and both enable registers are closed, and the violation flag is 0.
- R2: Word address map: configuration word r sits at address r (0 to NUM_CFG-1); lock i sits at 8+i; the enable pair sits at 12 (first) and 13 (second); the status word sits at 14. Any other address reads 0 and ignores writes. A configuration word changes only when written at its own address.
- R3: Writing the key of lock i to its address opens that lock. A write to the lock's target word presented 1 to WINDOW cycles after the key-write cycle is accepted. The default WINDOW is 4.
- R4: A lock closes on its own. A target write presented more than WINDOW cycles after the key write is dropped.
- R5: Writing zero, or any value other than its key, to a lock closes it from the next cycle. A wrong key never opens it.
- R6: A word guarded by the enable pair accepts writes only while the first enable register holds KICK_KEY0 and the second holds KICK_KEY1. Either key alone is not enough. The pair stays open with no time limit until one of its registers is rewritten with another value.
- R7: A word assigned to a lock ignores the enable pair. A lock opens only its own target word.
- R8: When the enable pair is not configured (KICK_EN=0), words with no lock are freely writable, while lock-assigned words still need their lock.
- R9: A dropped write to a guarded word sets the violation flag (pin `violation`, status bit 0). The flag stays set until reset. Accepted writes, and writes to lock, enable, status or unmapped addresses, do not set it.
- R10: Lock and enable registers read 1 in bit 0 while open and 0 while closed. Bits 31:1 read 0, so the key value is never returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| cfg_out | output | NUM_CFG*DATA_W | All configuration words, word r at bits r*DATA_W upward |
| violation | output | 1 | Sticky flag: a guarded write was dropped |

## Verification
The guarded write is tried at several distances from the key write: the very next cycle, exactly WINDOW cycles later, and one cycle beyond. These separate a correct relock from one cycle too early or too late. Locks are also hit with a zero write and a wrong key, and the enable pair with each key alone, with both keys, and after one key is overwritten. These separate an AND of the two registers from an OR, and a latched unlock from one that follows the last value written. Cross-scheme writes (lock key against another lock's word, enable pair against a lock-assigned word) and a second instance without the enable pair exercise the precedence rules.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;
  localparam int ADDR_W     = 4;
  localparam int TGT_W      = 4;
  localparam int LOCK_BASE  = 8;
  localparam int KICK0_ADDR = 12;
  localparam int KICK1_ADDR = 13;
  localparam int STAT_ADDR  = 14;

  function automatic logic [ADDR_W-1:0] aw(input int a);
    return ADDR_W'(a);
  endfunction
endpackage

// File: rtl/keyreg_lock.sv
// Single-key lock with a self-closing window.
module keyreg_lock #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = '1,
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              open
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (wr_hit) begin
      left_q <= (wdata == KEY) ? CNT_W'(WINDOW) : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign open = (left_q != '0);
endmodule

// File: rtl/keyreg_kick.sv
// Dual-key global enable pair; no time limit.
module keyreg_kick #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0 = '1,
  parameter logic [DATA_W-1:0] KEY1 = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wdata,
  output logic              held0,
  output logic              held1,
  output logic              open
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held0 <= 1'b0;
      held1 <= 1'b0;
    end else begin
      if (wr0) held0 <= (wdata == KEY0);
      if (wr1) held1 <= (wdata == KEY1);
    end
  end

  assign open = held0 & held1;
endmodule

// File: rtl/keyreg_gate.sv
// Decides, per configuration word, whether a write may land now.
module keyreg_gate #(
  parameter int NUM_CFG  = 6,
  parameter int NUM_LOCK = 2,
  parameter int TGT_W    = 4,
  parameter logic [NUM_LOCK*TGT_W-1:0] LOCK_TGT = '0,
  parameter bit KICK_EN = 1'b1
) (
  input  logic [NUM_LOCK-1:0] lock_open,
  input  logic                kick_open,
  output logic [NUM_CFG-1:0]  allow
);
  logic [NUM_CFG-1:0] owned;
  logic [NUM_CFG-1:0] lk_ok;

  always_comb begin
    owned = '0;
    lk_ok = '0;
    for (int r = 0; r < NUM_CFG; r++) begin
      for (int i = 0; i < NUM_LOCK; i++) begin
        if (int'(LOCK_TGT[i*TGT_W +: TGT_W]) == r) begin
          owned[r] = 1'b1;
          lk_ok[r] = lk_ok[r] | lock_open[i];
        end
      end
    end
    for (int r = 0; r < NUM_CFG; r++) begin
      if (owned[r])     allow[r] = lk_ok[r];
      else if (KICK_EN) allow[r] = kick_open;
      else              allow[r] = 1'b1;
    end
  end
endmodule

// File: rtl/keyreg_bank.sv
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CFG  = 6,
  parameter int NUM_LOCK = 2,
  parameter int WINDOW   = 4,
  parameter logic [NUM_LOCK*TGT_W-1:0]  LOCK_TGT  = 8'h31,
  parameter logic [NUM_LOCK*DATA_W-1:0] LOCK_KEYS = 64'h6B28_D4F2_5A17_C3E1,
  parameter bit KICK_EN = 1'b1,
  parameter logic [DATA_W-1:0] KICK_KEY0 = 32'h1357_9BDF,
  parameter logic [DATA_W-1:0] KICK_KEY1 = 32'h2468_ACE0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [NUM_CFG*DATA_W-1:0] cfg_out,
  output logic                      violation
);
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [NUM_LOCK-1:0]            lock_open;
  logic [NUM_CFG-1:0]             allow;
  logic kick_open, kick_held0, kick_held1;
  logic viol_q;

  for (genvar i = 0; i < NUM_LOCK; i++) begin : g_lock
    keyreg_lock #(
      .DATA_W(DATA_W),
      .KEY   (LOCK_KEYS[i*DATA_W +: DATA_W]),
      .WINDOW(WINDOW)
    ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(bus_we && (bus_addr == aw(LOCK_BASE + i))),
      .wdata (bus_wdata),
      .open  (lock_open[i])
    );
  end

  if (KICK_EN) begin : g_kick
    keyreg_kick #(
      .DATA_W(DATA_W),
      .KEY0  (KICK_KEY0),
      .KEY1  (KICK_KEY1)
    ) u_kick (
      .clk  (clk),
      .rst_n(rst_n),
      .wr0  (bus_we && (bus_addr == aw(KICK0_ADDR))),
      .wr1  (bus_we && (bus_addr == aw(KICK1_ADDR))),
      .wdata(bus_wdata),
      .held0(kick_held0),
      .held1(kick_held1),
      .open (kick_open)
    );
  end else begin : g_nokick
    assign kick_held0 = 1'b0;
    assign kick_held1 = 1'b0;
    assign kick_open  = 1'b0;
  end

  keyreg_gate #(
    .NUM_CFG (NUM_CFG),
    .NUM_LOCK(NUM_LOCK),
    .TGT_W   (TGT_W),
    .LOCK_TGT(LOCK_TGT),
    .KICK_EN (KICK_EN)
  ) u_gate (
    .lock_open(lock_open),
    .kick_open(kick_open),
    .allow    (allow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      viol_q <= 1'b0;
    end else if (bus_we) begin
      for (int r = 0; r < NUM_CFG; r++) begin
        if (bus_addr == aw(r)) begin
          if (allow[r]) cfg_q[r] <= bus_wdata;
          else          viol_q   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_CFG; r++) begin
      if (bus_addr == aw(r)) bus_rdata = cfg_q[r];
    end
    for (int i = 0; i < NUM_LOCK; i++) begin
      if (bus_addr == aw(LOCK_BASE + i)) bus_rdata = DATA_W'(lock_open[i]);
    end
    if (bus_addr == aw(KICK0_ADDR)) bus_rdata = DATA_W'(kick_held0);
    if (bus_addr == aw(KICK1_ADDR)) bus_rdata = DATA_W'(kick_held1);
    if (bus_addr == aw(STAT_ADDR))  bus_rdata = DATA_W'(viol_q);
  end

  assign cfg_out   = cfg_q;
  assign violation = viol_q;
endmodule

// File: rtl/keyreg_bank_chk.sv
module keyreg_bank_chk
  import keyreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CFG  = 6,
  parameter int NUM_LOCK = 2,
  parameter int WINDOW   = 4,
  parameter logic [NUM_LOCK*TGT_W-1:0]  LOCK_TGT  = '0,
  parameter logic [NUM_LOCK*DATA_W-1:0] LOCK_KEYS = '0,
  parameter logic [DATA_W-1:0] KICK_KEY0 = '1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [NUM_CFG*DATA_W-1:0] cfg_out,
  input logic                      violation,
  input logic [NUM_LOCK-1:0]       lock_open,
  input logic                      kick_open
);
  localparam int SW = $clog2(WINDOW + 2);

  // R9: sticky flag
  a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R6: a non-key value in the first enable register shuts the pair
  a_r6_kick_shut: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == aw(KICK0_ADDR) && bus_wdata != KICK_KEY0) |=> !kick_open);

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_word
    // R2: a word moves only when addressed
    a_r2_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == aw(r)) |=> $stable(cfg_out[r*DATA_W +: DATA_W]));
  end

  for (genvar i = 0; i < NUM_LOCK; i++) begin : g_lk
    localparam int T = int'(LOCK_TGT[i*TGT_W +: TGT_W]);
    logic [SW-1:0] since;
    always_ff @(posedge clk) begin
      if (!rst_n) since <= '0;
      else if (bus_we && bus_addr == aw(LOCK_BASE + i) &&
               bus_wdata == LOCK_KEYS[i*DATA_W +: DATA_W]) since <= SW'(1);
      else if (since != '0 && since <= SW'(WINDOW)) since <= since + 1'b1;
    end

    // R4: lock is open only inside the window after its key write
    a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
      lock_open[i] |-> (since != '0 && since <= SW'(WINDOW)));

    // R5: zero write shuts the lock
    a_r5_zero_shuts: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == aw(LOCK_BASE + i) && bus_wdata == '0) |=> !lock_open[i]);

    if (T < NUM_CFG) begin : g_tgt
      // R3: write to a closed target is dropped and flagged
      a_r3_closed_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == aw(T) && !lock_open[i])
        |=> ($stable(cfg_out[T*DATA_W +: DATA_W]) && violation));
    end
  end
endmodule

bind keyreg_bank keyreg_bank_chk #(
  .DATA_W   (DATA_W),
  .NUM_CFG  (NUM_CFG),
  .NUM_LOCK (NUM_LOCK),
  .WINDOW   (WINDOW),
  .LOCK_TGT (LOCK_TGT),
  .LOCK_KEYS(LOCK_KEYS),
  .KICK_KEY0(KICK_KEY0)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cfg_out  (cfg_out),
  .violation(violation),
  .lock_open(lock_open),
  .kick_open(kick_open)
);

// File: tb/keyreg_bank_bench.sv
`timescale 1ns/1ps
module keyreg_bank_bench;
  localparam logic [31:0] K_L0 = 32'h5A17_C3E1;  // lock 0 -> word 1
  localparam logic [31:0] K_L1 = 32'h6B28_D4F2;  // lock 1 -> word 3
  localparam logic [31:0] K_A  = 32'h1357_9BDF;
  localparam logic [31:0] K_B  = 32'h2468_ACE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we [2];
  logic [3:0] addr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic [6*32-1:0] cfg [2];
  logic viol [2];
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  keyreg_bank u_keyreg_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(we[0]), .bus_addr(addr[0]),
    .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .cfg_out(cfg[0]),
    .violation(viol[0]));

  keyreg_bank #(.KICK_EN(1'b0)) u_keyreg_bank_free (
    .clk(clk), .rst_n(rst_n), .bus_we(we[1]), .bus_addr(addr[1]),
    .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .cfg_out(cfg[1]),
    .violation(viol[1]));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input int u, input logic [3:0] a, input logic [31:0] d);
    we[u] = 1'b1; addr[u] = a; wdata[u] = d;
    @(negedge clk);
    we[u] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input int u, input logic [3:0] a, input logic [31:0] exp,
                        input string req, input string what);
    we[u] = 1'b0; addr[u] = a;
    #1;
    chk(req, what, rdata[u], exp);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    for (int r = 0; r < 6; r++) rd_chk(0, 4'(r), 32'h0, "R1", "word after reset");
    rd_chk(0, 4'd8, 32'h0, "R1", "lock0 closed");
    rd_chk(0, 4'd9, 32'h0, "R1", "lock1 closed");
    rd_chk(0, 4'd12, 32'h0, "R1", "enable A closed");
    rd_chk(0, 4'd13, 32'h0, "R1", "enable B closed");
    rd_chk(0, 4'd14, 32'h0, "R1", "status clear");
    chk("R1", "violation pin", 32'(viol[0]), 32'h0);
  endtask

  task automatic t_lock_window;
    do_reset;
    wr(0, 4'd8, K_L0);
    rd_chk(0, 4'd8, 32'h1, "R10", "lock0 reads 1 when open");
    wr(0, 4'd1, 32'h1111_0001);
    rd_chk(0, 4'd1, 32'h1111_0001, "R3", "write right after key");
    wr(0, 4'd8, K_L0);
    idle(3);
    wr(0, 4'd1, 32'h2222_0004);
    rd_chk(0, 4'd1, 32'h2222_0004, "R3", "write at window edge");
    chk("R9", "no flag on accepted writes", 32'(viol[0]), 32'h0);
    wr(0, 4'd8, K_L0);
    idle(4);
    wr(0, 4'd1, 32'h3333_0005);
    rd_chk(0, 4'd1, 32'h2222_0004, "R4", "write past window dropped");
    rd_chk(0, 4'd8, 32'h0, "R4", "lock0 reads closed after window");
    chk("R9", "flag after drop", 32'(viol[0]), 32'h1);
    wr(0, 4'd8, K_L0);
    wr(0, 4'd1, 32'h4444_0001);
    rd_chk(0, 4'd14, 32'h1, "R9", "flag stays after good write");
  endtask

  task automatic t_close;
    do_reset;
    wr(0, 4'd8, K_L0);
    wr(0, 4'd8, 32'h0);
    rd_chk(0, 4'd8, 32'h0, "R5", "zero closes lock0");
    wr(0, 4'd1, 32'h5555_0000);
    rd_chk(0, 4'd1, 32'h0, "R5", "write after zero dropped");
    do_reset;
    wr(0, 4'd8, K_L0 ^ 32'h1);
    rd_chk(0, 4'd8, 32'h0, "R5", "wrong key leaves lock closed");
    wr(0, 4'd1, 32'h5555_0001);
    rd_chk(0, 4'd1, 32'h0, "R5", "write after wrong key dropped");
    wr(0, 4'd9, K_L1);
    wr(0, 4'd3, 32'h5555_0003);
    rd_chk(0, 4'd3, 32'h5555_0003, "R3", "lock1 opens word 3");
  endtask

  task automatic t_kick;
    do_reset;
    wr(0, 4'd12, K_A);
    rd_chk(0, 4'd12, 32'h1, "R10", "enable A reads 1 not key");
    rd_chk(0, 4'd13, 32'h0, "R10", "enable B reads 0");
    wr(0, 4'd2, 32'hAAAA_0002);
    rd_chk(0, 4'd2, 32'h0, "R6", "first key alone not enough");
    do_reset;
    wr(0, 4'd13, K_B);
    wr(0, 4'd2, 32'hAAAA_0003);
    rd_chk(0, 4'd2, 32'h0, "R6", "second key alone not enough");
    do_reset;
    wr(0, 4'd12, K_A);
    wr(0, 4'd13, K_B);
    idle(10);
    wr(0, 4'd2, 32'hBBBB_0002);
    rd_chk(0, 4'd2, 32'hBBBB_0002, "R6", "both keys, no time limit");
    chk("R9", "no flag on enabled write", 32'(viol[0]), 32'h0);
    wr(0, 4'd12, 32'h0);
    wr(0, 4'd2, 32'hCCCC_0002);
    rd_chk(0, 4'd2, 32'hBBBB_0002, "R6", "dropped after key overwritten");
    chk("R9", "flag after drop", 32'(viol[0]), 32'h1);
  endtask

  task automatic t_precedence;
    do_reset;
    wr(0, 4'd12, K_A);
    wr(0, 4'd13, K_B);
    wr(0, 4'd1, 32'h6666_0001);
    rd_chk(0, 4'd1, 32'h0, "R7", "enable pair ignored by locked word");
    wr(0, 4'd0, 32'h7777_0000);
    rd_chk(0, 4'd0, 32'h7777_0000, "R7", "enable pair opens unlocked word");
    do_reset;
    wr(0, 4'd8, K_L0);
    wr(0, 4'd3, 32'h8888_0003);
    rd_chk(0, 4'd3, 32'h0, "R7", "lock0 does not open word 3");
  endtask

  task automatic t_map;
    do_reset;
    wr(0, 4'd7, 32'h9999_0007);
    wr(0, 4'd15, 32'h9999_000F);
    wr(0, 4'd14, 32'hFFFF_FFFF);
    for (int r = 0; r < 6; r++) rd_chk(0, 4'(r), 32'h0, "R2", "unmapped write leaves words");
    rd_chk(0, 4'd7, 32'h0, "R2", "unmapped reads 0");
    chk("R9", "no flag on unmapped/status write", 32'(viol[0]), 32'h0);
  endtask

  task automatic t_free;
    do_reset;
    wr(1, 4'd2, 32'h1234_0002);
    rd_chk(1, 4'd2, 32'h1234_0002, "R8", "free word writable");
    chk("R8", "word 2 on output pins", cfg[1][2*32 +: 32], 32'h1234_0002);
    chk("R8", "no flag on free write", 32'(viol[1]), 32'h0);
    wr(1, 4'd1, 32'h1234_0001);
    rd_chk(1, 4'd1, 32'h0, "R8", "locked word still needs lock");
    wr(1, 4'd8, K_L0);
    wr(1, 4'd1, 32'h1234_0011);
    rd_chk(1, 4'd1, 32'h1234_0011, "R8", "locked word opens with its key");
  endtask

  initial begin
    we[0] = 1'b0; we[1] = 1'b0;
    addr[0] = '0; addr[1] = '0;
    wdata[0] = '0; wdata[1] = '0;
    idle(1);
    do_reset;
    t_reset;
    t_lock_window;
    t_close;
    t_kick;
    t_precedence;
    t_map;
    t_free;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule